// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This unit resolves the two register-indirect control-transfer instructions of a 32-bit load-store core: a plain conditional branch and a conditional branch that also saves the return address. When it is given an instruction word and the already-advanced program counter, it reads two registers from an outside register file. One holds the target and one is tested. It checks the tested register against a 3-bit condition code and reports whether the branch is taken and which PC comes next. The branch target always comes from a register. The instruction never carries an immediate target.

The unit runs as a small state machine. In `ST_IDLE` it waits for `start`. The transition *accept* moves it to `ST_READ`. In `ST_READ` it presents the two register addresses, and the register file answers in the same cycle. The transition *capture* latches both values and moves to `ST_RESOLVE`. In `ST_RESOLVE` it drives `done` for one cycle together with the result and any link write. The transition *retire* then returns it to `ST_IDLE`. The link write reaches the register file on the edge that ends `ST_RESOLVE`. By then both operands were latched a cycle earlier, so an instruction whose destination register is also its target or test register sees the old values.

Top module: `branch_link_unit`

## Requirements
- R1: After reset the unit is idle: `done`, `link_we`, `taken` and `illegal_cond` are 0.
- R2: A `start` seen in idle leads to `done` high for exactly one cycle, two clock edges later. During the cycle in between, `rd_addr_tgt` carries instruction bits 21:17 and `rd_addr_cond` carries bits 16:12.
- R3: The opcode sits in bits 31:27. Value 8 is a plain branch and 9 is branch-and-link. Any other value gives `is_branch`=0, `taken`=0, `illegal_cond`=0, `link_we`=0 and `next_pc`=`cur_pc`.
- R4: The condition is instruction bits 2:0, and the tested value is the condition register. Code 0 is never taken and 1 is always taken. Code 2 is taken when the value is zero and 3 when it is nonzero. Code 4 is taken when bit 31 is 0 and 5 when bit 31 is 1.
- R5: Codes 6 and 7 on a branch opcode are never taken and raise `illegal_cond` in the `done` cycle.
- R6: In the `done` cycle `next_pc` equals the target register value when taken, and `cur_pc` otherwise.
- R7: For opcode 9, `link_we` is high in the `done` cycle whether or not the branch is taken. `link_addr` is instruction bits 26:22 and `link_data` is the `cur_pc` given with `start`. Opcode 8 never raises `link_we`.
- R8: When the link destination equals the target or test register, the condition and `next_pc` use the values from before the link write.
- R9: A `start` that arrives while the unit is busy is ignored. The current result is unchanged and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to resolve `instr` |
| instr | input | 32 | Instruction word |
| cur_pc | input | 32 | PC already advanced past the instruction |
| rd_addr_tgt | output | 5 | Target register read address |
| rd_addr_cond | output | 5 | Test register read address |
| rd_data_tgt | input | 32 | Target register value (same-cycle read) |
| rd_data_cond | input | 32 | Test register value (same-cycle read) |
| done | output | 1 | Result valid, one cycle |
| is_branch | output | 1 | Opcode was a branch form |
| taken | output | 1 | Branch taken |
| illegal_cond | output | 1 | Reserved condition code used |
| next_pc | output | 32 | Next PC |
| link_we | output | 1 | Link write enable |
| link_addr | output | 5 | Link destination register |
| link_data | output | 32 | Value to link |

## Verification
The case that is hardest to reach from the ports is a branch-and-link whose destination register is also its target or test register. In that case the link write and the operand read land on the same register a cycle apart. The bench builds such instructions on purpose, and it also draws random field values with a bias toward equal register numbers. Its register-file model then applies the link write, so a design that read too late would see the already-linked PC. The sign-boundary values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are forced into the test register for every condition code.

// File: rtl/blu_pkg.sv
package blu_pkg;
    localparam int unsigned XLEN    = 32;
    localparam int unsigned RIDX_W  = 5;
    localparam int unsigned OPC_W   = 5;
    localparam int unsigned CC_W    = 3;

    localparam logic [OPC_W-1:0] OPC_BR  = 5'd8;
    localparam logic [OPC_W-1:0] OPC_BRL = 5'd9;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_RESOLVE = 2'd2
    } blu_state_t;

    typedef enum logic [CC_W-1:0] {
        CC_NEVER  = 3'd0,
        CC_ALWAYS = 3'd1,
        CC_ZERO   = 3'd2,
        CC_NZERO  = 3'd3,
        CC_PLUS   = 3'd4,
        CC_MINUS  = 3'd5
    } blu_cc_t;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] dst;
        logic [RIDX_W-1:0] tgt;
        logic [RIDX_W-1:0] tst;
        logic [CC_W-1:0]   cc;
    } blu_fields_t;
endpackage

// File: rtl/blu_decode.sv
module blu_decode
    import blu_pkg::*;
#(
    parameter int unsigned IW = 32
) (
    input  logic [IW-1:0] word,
    output blu_fields_t   fld,
    output logic          is_br,
    output logic          is_link
);
    localparam int unsigned OPC_LSB = IW - OPC_W;
    localparam int unsigned DST_LSB = OPC_LSB - RIDX_W;
    localparam int unsigned TGT_LSB = DST_LSB - RIDX_W;
    localparam int unsigned TST_LSB = TGT_LSB - RIDX_W;

    always_comb begin
        fld.opc = word[OPC_LSB +: OPC_W];
        fld.dst = word[DST_LSB +: RIDX_W];
        fld.tgt = word[TGT_LSB +: RIDX_W];
        fld.tst = word[TST_LSB +: RIDX_W];
        fld.cc  = word[CC_W-1:0];
        is_link = (fld.opc == OPC_BRL);
        is_br   = (fld.opc == OPC_BR) || is_link;
    end
endmodule

// File: rtl/blu_cond_eval.sv
module blu_cond_eval
    import blu_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [CC_W-1:0] cc,
    input  logic [DW-1:0]   val,
    output logic            pass,
    output logic            bad_code
);
    logic zero_v;
    logic neg_v;

    always_comb begin
        zero_v   = (val == '0);
        neg_v    = val[DW-1];
        pass     = 1'b0;
        bad_code = 1'b0;
        unique case (cc)
            CC_NEVER:  pass = 1'b0;
            CC_ALWAYS: pass = 1'b1;
            CC_ZERO:   pass = zero_v;
            CC_NZERO:  pass = !zero_v;
            CC_PLUS:   pass = !neg_v;
            CC_MINUS:  pass = neg_v;
            default:   bad_code = 1'b1;
        endcase
    end
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
    import blu_pkg::*;
#(
    parameter int unsigned DW = XLEN,
    parameter int unsigned AW = RIDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] instr,
    input  logic [DW-1:0] cur_pc,
    output logic [AW-1:0] rd_addr_tgt,
    output logic [AW-1:0] rd_addr_cond,
    input  logic [DW-1:0] rd_data_tgt,
    input  logic [DW-1:0] rd_data_cond,
    output logic          done,
    output logic          is_branch,
    output logic          taken,
    output logic          illegal_cond,
    output logic [DW-1:0] next_pc,
    output logic          link_we,
    output logic [AW-1:0] link_addr,
    output logic [DW-1:0] link_data
);
    blu_state_t  state_q, state_d;
    logic [DW-1:0] instr_q, pc_q, tgt_q, tst_q;
    blu_fields_t fld;
    logic        dec_br, dec_link, cc_pass, cc_bad;

    blu_decode #(.IW(DW)) u_dec (
        .word    (instr_q),
        .fld     (fld),
        .is_br   (dec_br),
        .is_link (dec_link)
    );

    blu_cond_eval #(.DW(DW)) u_cond (
        .cc       (fld.cc),
        .val      (tst_q),
        .pass     (cc_pass),
        .bad_code (cc_bad)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_READ;
            ST_READ:    state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            instr_q <= '0;
            pc_q    <= '0;
            tgt_q   <= '0;
            tst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                instr_q <= instr;
                pc_q    <= cur_pc;
            end
            if (state_q == ST_READ) begin
                tgt_q <= rd_data_tgt;
                tst_q <= rd_data_cond;
            end
        end
    end

    always_comb begin
        rd_addr_tgt  = fld.tgt;
        rd_addr_cond = fld.tst;
        done         = 1'b0;
        is_branch    = 1'b0;
        taken        = 1'b0;
        illegal_cond = 1'b0;
        next_pc      = pc_q;
        link_we      = 1'b0;
        link_addr    = fld.dst;
        link_data    = pc_q;
        unique case (state_q)
            ST_RESOLVE: begin
                done         = 1'b1;
                is_branch    = dec_br;
                taken        = dec_br && cc_pass;
                illegal_cond = dec_br && cc_bad;
                next_pc      = (dec_br && cc_pass) ? tgt_q : pc_q;
                link_we      = dec_link;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_link_unit_chk.sv
module branch_link_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        done,
    input logic        is_branch,
    input logic        taken,
    input logic        illegal_cond,
    input logic        link_we,
    input logic [31:0] next_pc,
    input logic [31:0] rd_data_tgt
);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    link_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (done && is_branch));
    // R3
    taken_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (done && is_branch));
    // R5
    illegal_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cond |-> !taken);
    // R6
    taken_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && taken) |-> (next_pc == $past(rd_data_tgt)));
endmodule

bind branch_link_unit branch_link_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .is_branch    (is_branch),
    .taken        (taken),
    .illegal_cond (illegal_cond),
    .link_we      (link_we),
    .next_pc      (next_pc),
    .rd_data_tgt  (rd_data_tgt)
);

// File: tb/test_branch_link_unit.sv
module test_branch_link_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] cur_pc = '0;
    logic [4:0]  rd_addr_tgt, rd_addr_cond, link_addr;
    logic [31:0] rd_data_tgt, rd_data_cond, next_pc, link_data;
    logic        done, is_branch, taken, illegal_cond, link_we;
    logic [31:0] regs [32];
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    assign rd_data_tgt  = regs[rd_addr_tgt];
    assign rd_data_cond = regs[rd_addr_cond];

    always @(posedge clk) if (link_we) regs[link_addr] <= link_data;

    branch_link_unit i_branch_link_unit (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [4:0] rc, input logic [2:0] cc);
        return {op, ra, rb, rc, 9'd0, cc};
    endfunction

    function automatic logic exp_take(input logic [2:0] cc, input logic [31:0] v);
        case (cc)
            3'd1: return 1'b1;
            3'd2: return v == 0;
            3'd3: return v != 0;
            3'd4: return !v[31];
            3'd5: return v[31];
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input logic [31:0] iw, input logic [31:0] pc, input logic busy_start);
        logic [4:0] op, ra, rb, rc;
        logic [2:0] cc;
        logic br, lk, tk;
        logic [31:0] tv, cv, ra_old;
        op = iw[31:27]; ra = iw[26:22]; rb = iw[21:17]; rc = iw[16:12]; cc = iw[2:0];
        br = (op == 5'd8) || (op == 5'd9);
        lk = (op == 5'd9);
        tv = regs[rb]; cv = regs[rc]; ra_old = regs[ra];
        tk = br && exp_take(cc, cv);
        @(negedge clk);
        instr = iw; cur_pc = pc; start = 1'b1;
        @(negedge clk);
        start = busy_start;
        instr = ~iw; cur_pc = ~pc;
        chk("R2", "done early", {31'd0, done}, 32'd0);
        chk("R2", "tgt addr", {27'd0, rd_addr_tgt}, {27'd0, rb});
        chk("R2", "cond addr", {27'd0, rd_addr_cond}, {27'd0, rc});
        @(negedge clk);
        start = 1'b0;
        chk("R2", "done", {31'd0, done}, 32'd1);
        chk("R3", "is_branch", {31'd0, is_branch}, {31'd0, br});
        chk("R4", "taken", {31'd0, taken}, {31'd0, tk});
        chk("R5", "illegal", {31'd0, illegal_cond}, {31'd0, br && cc > 3'd5});
        chk("R6", "next_pc", next_pc, tk ? tv : pc);
        chk("R7", "link_we", {31'd0, link_we}, {31'd0, lk});
        if (lk) begin
            chk("R7", "link_addr", {27'd0, link_addr}, {27'd0, ra});
            chk("R7", "link_data", link_data, pc);
        end
        @(negedge clk);
        chk("R9", "done after", {31'd0, done}, 32'd0);
        chk("R7", "reg after", regs[ra], lk ? pc : ra_old);
        @(negedge clk);
        chk("R9", "idle stays", {31'd0, done}, 32'd0);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd77));
        for (int i = 0; i < 32; i++) regs[i] = 32'h1000 * i + 32'h44;
        repeat (3) @(negedge clk);
        chk("R1", "done", {31'd0, done}, 32'd0);
        chk("R1", "link_we", {31'd0, link_we}, 32'd0);
        chk("R1", "taken", {31'd0, taken}, 32'd0);
        chk("R1", "illegal", {31'd0, illegal_cond}, 32'd0);
        rst_n = 1'b1;
        // R4 R5: every code against sign-boundary test values, both opcodes
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 4; k++) begin
                regs[3] = (k == 0) ? 32'h0 : (k == 1) ? 32'h7FFFFFFF :
                          (k == 2) ? 32'h80000000 : 32'hFFFFFFFF;
                run(mk(5'd8 + 5'(k & 1), 5'd7, 5'd2, 5'd3, 3'(c)), 32'h100 + 32'(c), 1'b0);
            end
        end
        // R3: non-branch opcodes
        run(mk(5'd12, 5'd4, 5'd2, 5'd0, 3'd1), 32'h2000, 1'b0);
        run(mk(5'd0,  5'd4, 5'd2, 5'd0, 3'd1), 32'h2004, 1'b0);
        // R8: destination equals target and test register
        regs[6] = 32'hABCD0000;
        run(mk(5'd9, 5'd6, 5'd6, 5'd6, 3'd3), 32'h3000, 1'b0);
        regs[6] = 32'h0;
        run(mk(5'd9, 5'd6, 5'd5, 5'd6, 3'd2), 32'h3004, 1'b0);
        // R7: link with not taken
        run(mk(5'd9, 5'd9, 5'd5, 5'd6, 3'd0), 32'h3008, 1'b0);
        // R9: start while busy
        run(mk(5'd8, 5'd1, 5'd5, 5'd6, 3'd1), 32'h4000, 1'b1);
        // random mix, biased to small register numbers so indices collide
        for (int n = 0; n < 300; n++) begin
            logic [4:0] ra, rb, rc;
            ra = 5'($urandom % 6); rb = 5'($urandom % 6); rc = 5'($urandom % 6);
            regs[rc] = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            regs[rb] = $urandom;
            run(mk(5'd8 + 5'($urandom % 2), ra, rb, rc, 3'($urandom)), $urandom, 1'($urandom % 5 == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule